// File: doc/BRIEF.md
# Fine Horizontal Scroll Pixel Aligner

This block lines up the pixels of one background plane with that plane's horizontal scroll value. Pixel data comes in as 16-pixel groups, two cells at a time. The first group of every line is the column to the left of the screen, and it is fetched whatever the scroll value is. The fetch addresses never depend on the fine part of the scroll. Instead, a 4-bit hold-off counter is loaded with the low four scroll bits at the start of each line. While it is not zero, it stops the group shift register from advancing. The fine offset therefore ends up in the left border, and the first visible pixel falls in the right place.

Each line begins with a 16-pixel left border, followed by an active area of 256 or 320 pixels, chosen by a width bit that is captured at line start. A holding register takes the next group while the current one is still being shifted out. The held group moves into the shift register when the current group is used up. If no group is waiting at that point, the output pixel is transparent (0) and the stream does not advance.

The output is registered: one pixel per pixel-clock tick, an active flag, and the index of that pixel within the active area. Outside the active area the pixel is forced to 0.

Top module: `fhs_aligner`

## Requirements
- R1: After reset, `pix_out`, `pix_act` and `pix_x` are all 0, and they stay 0 until a line starts.
- R2: A `line_start` pulse loads the hold-off counter with `scroll[3:0]`. Bits above bit 3 of `scroll` have no effect on the output.
- R3: Line position p counts the `pix_en` ticks after `line_start`, starting at 0. With fine offset s = `scroll[3:0]`, no pixel is taken from the group stream during ticks p < s.
- R4: The group stream is numbered from 0, where stream pixel j is pixel j mod 16 of group j/16, and group 0 is the leading left column. Pixel i of a group sits at `col_data[i*4 +: 4]`. At tick p ≥ s, stream pixel p − s is taken.
- R5: When s = 0, all 16 pixels of group 0 are taken during the border ticks p < 16, and none of them appears while `pix_act` is 1.
- R6: Ticks 16 ≤ p < 16+W are active, where W = 256 when `wide` = 0 and W = 320 when `wide` = 1 (captured at `line_start`). Only on active ticks is `pix_act` 1; on all other ticks `pix_out` is 0. After the active area, the position stops advancing until the next line.
- R7: On an active tick, `pix_x` = p − 16. On all other ticks it is 0.
- R8: A tick that finds the current group used up and no group held outputs 0 and takes nothing from the stream. The stream resumes without loss once a group arrives.
- R9: A group delivered on `col_valid` while another group is being shifted is kept until the current group is used up, and is then output in order.
- R10: Outputs change only on the cycle after a `pix_en` tick; cycles with `pix_en` low leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel clock enable (one tick per pixel) |
| line_start | input | 1 | Start-of-line strobe; loads the hold-off counter and clears the buffers |
| wide | input | 1 | Width select: 0 for 256 active pixels, 1 for 320 |
| scroll | input | 10 | Horizontal scroll value; only bits 3:0 are used |
| col_valid | input | 1 | A 16-pixel group is presented on `col_data` |
| col_data | input | 64 | 16 pixels of 4 bits, with pixel 0 in the low bits |
| pix_out | output | 4 | Output pixel, 0 outside the active area |
| pix_act | output | 1 | The output pixel belongs to the active area |
| pix_x | output | 9 | Index of the output pixel within the active area |

## Verification
The assertions assume that `col_valid` arrives only when the holding register is empty, or in the cycle in which its group moves into the shift register. They also assume that `line_start` and `col_valid` are never high in the same cycle. The stimulus keeps to both rules by working out, from the scroll offset and any deliberate gap, the tick at which each group is consumed. It delivers the next group only in the idle cycle after that tick. The first group of a line is delivered in a cycle of its own after `line_start`. The sweep covers all 16 fine offsets in both widths, with the upper scroll bits varied. Extra lines hold back one group to cause underflow gaps of several lengths.

// File: rtl/fhs_pkg.sv
package fhs_pkg;
    localparam int unsigned GRP_PIX    = 16;
    localparam int unsigned FINE_W     = 4;
    localparam int unsigned BORDER_PIX = 16;
    localparam int unsigned NARROW_PIX = 256;
    localparam int unsigned WIDE_PIX   = 320;
    localparam int unsigned POS_W      = $clog2(BORDER_PIX + WIDE_PIX + 1);
    localparam int unsigned REM_W      = $clog2(GRP_PIX + 1);

    typedef struct packed {
        logic [FINE_W-1:0] cnt;
    } delay_st_t;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             wide;
    } pos_st_t;
endpackage

// File: rtl/fhs_delay_ctr.sv
module fhs_delay_ctr
    import fhs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              tick,
    input  logic [FINE_W-1:0] fine,
    output logic              expired
);
    delay_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = fine;
        end else if (tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired = (st_q.cnt == '0);

    assert_load_fine_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.cnt == $past(fine)));

    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && (st_q.cnt != '0)) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(st_q.cnt));
endmodule

// File: rtl/fhs_pos_ctr.sv
module fhs_pos_ctr
    import fhs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic             wide_in,
    output logic             in_line,
    output logic             active,
    output logic [POS_W-1:0] x_idx
);
    localparam logic [POS_W-1:0] END_NARROW = POS_W'(BORDER_PIX + NARROW_PIX);
    localparam logic [POS_W-1:0] END_WIDE   = POS_W'(BORDER_PIX + WIDE_PIX);
    localparam logic [POS_W-1:0] BORDER     = POS_W'(BORDER_PIX);

    pos_st_t st_d, st_q;
    logic [POS_W-1:0] line_end;

    always_comb begin
        line_end = st_q.wide ? END_WIDE : END_NARROW;
        in_line  = (st_q.pos < line_end);
        active   = in_line && (st_q.pos >= BORDER);
        x_idx    = active ? (st_q.pos - BORDER) : '0;
    end

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.pos  = '0;
            st_d.wide = wide_in;
        end else if (tick && in_line) begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pos  <= END_WIDE;
            st_q.wide <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_pos_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_line && !load) |=> $stable(st_q.pos));

    assert_pos_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.pos == '0));
endmodule

// File: rtl/fhs_col_buffer.sv
module fhs_col_buffer
    import fhs_pkg::*;
#(
    parameter int unsigned PIX_W = 4,
    localparam int unsigned GRP_BITS = PIX_W * GRP_PIX
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                shift,
    input  logic                col_valid,
    input  logic [GRP_BITS-1:0] col_data,
    output logic [PIX_W-1:0]    pix
);
    typedef struct packed {
        logic [GRP_BITS-1:0] hold;
        logic                hold_vld;
        logic [GRP_BITS-1:0] sh;
        logic [REM_W-1:0]    rem;
    } buf_st_t;

    buf_st_t st_d, st_q;
    logic    take;

    always_comb begin
        st_d = st_q;
        pix  = '0;
        take = 1'b0;
        if (clear) begin
            st_d.hold_vld = 1'b0;
            st_d.rem      = '0;
        end else begin
            if (shift) begin
                if (st_q.rem != '0) begin
                    pix       = st_q.sh[PIX_W-1:0];
                    st_d.sh   = st_q.sh >> PIX_W;
                    st_d.rem  = st_q.rem - 1'b1;
                end else if (st_q.hold_vld) begin
                    take          = 1'b1;
                    pix           = st_q.hold[PIX_W-1:0];
                    st_d.sh       = st_q.hold >> PIX_W;
                    st_d.rem      = REM_W'(GRP_PIX - 1);
                    st_d.hold_vld = 1'b0;
                end
            end
            if (col_valid) begin
                st_d.hold     = col_data;
                st_d.hold_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_hold_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(col_valid && st_q.hold_vld && !take && !clear));

    assert_no_start_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(col_valid && clear));

    assert_underflow_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !clear && (st_q.rem == '0) && !st_q.hold_vld) |=> (st_q.rem == '0));

    assert_no_shift_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !clear) |=> $stable(st_q.rem));
endmodule

// File: rtl/fhs_aligner.sv
module fhs_aligner
    import fhs_pkg::*;
#(
    parameter int unsigned PIX_W    = 4,
    parameter int unsigned SCROLL_W = 10,
    localparam int unsigned GRP_BITS = PIX_W * GRP_PIX
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pix_en,
    input  logic                line_start,
    input  logic                wide,
    input  logic [SCROLL_W-1:0] scroll,
    input  logic                col_valid,
    input  logic [GRP_BITS-1:0] col_data,
    output logic [PIX_W-1:0]    pix_out,
    output logic                pix_act,
    output logic [POS_W-1:0]    pix_x
);
    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic             act;
        logic [POS_W-1:0] x;
    } out_st_t;

    out_st_t          st_d, st_q;
    logic             tick;
    logic             expired;
    logic             in_line;
    logic             active;
    logic [POS_W-1:0] x_idx;
    logic             shift;
    logic [PIX_W-1:0] buf_pix;

    assign tick  = pix_en && !line_start;
    assign shift = tick && in_line && expired;

    fhs_delay_ctr u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (line_start),
        .tick    (tick),
        .fine    (scroll[FINE_W-1:0]),
        .expired (expired)
    );

    fhs_pos_ctr u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (line_start),
        .tick    (tick),
        .wide_in (wide),
        .in_line (in_line),
        .active  (active),
        .x_idx   (x_idx)
    );

    fhs_col_buffer #(.PIX_W(PIX_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (line_start),
        .shift     (shift),
        .col_valid (col_valid),
        .col_data  (col_data),
        .pix       (buf_pix)
    );

    always_comb begin
        st_d = st_q;
        if (line_start) begin
            st_d = '0;
        end else if (tick) begin
            st_d.act = active;
            st_d.pix = active ? buf_pix : '0;
            st_d.x   = x_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_out = st_q.pix;
    assign pix_act = st_q.act;
    assign pix_x   = st_q.x;

    assert_border_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_act |-> (pix_out == '0));

    assert_border_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_act |-> (pix_x == '0));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_en && !line_start) |=> ($stable(pix_out) && $stable(pix_act) && $stable(pix_x)));

    assert_index_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pix_act && active) |=> (pix_x == $past(pix_x) + 1'b1));
endmodule

// File: tb/tb_fhs_aligner.sv
`timescale 1ns/1ps
module tb_fhs_aligner;
    localparam int PW = 4;
    localparam int NOGAP = 999;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_en = 1'b0;
    logic          line_start = 1'b0;
    logic          wide = 1'b0;
    logic [9:0]    scroll = '0;
    logic          col_valid = 1'b0;
    logic [63:0]   col_data = '0;
    logic [PW-1:0] pix_out;
    logic          pix_act;
    logic [8:0]    pix_x;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fhs_aligner dut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_start(line_start),
        .wide(wide), .scroll(scroll), .col_valid(col_valid), .col_data(col_data),
        .pix_out(pix_out), .pix_act(pix_act), .pix_x(pix_x)
    );

    function automatic int pval(int line, int g, int i);
        return ((line * 5 + g * 3 + i * 7) % 15) + 1;
    endfunction

    function automatic logic [63:0] grp(int line, int g);
        logic [63:0] v = '0;
        for (int i = 0; i < 16; i++) v[i*4 +: 4] = 4'(pval(line, g, i));
        return v;
    endfunction

    function automatic int load_tick(int s, int g, int gg, int d);
        return s + 16 * g + ((g >= gg) ? d : 0);
    endfunction

    task automatic check(string req, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic do_tick();
        pix_en = 1'b1;
        @(posedge clk); #1;
        pix_en = 1'b0;
    endtask

    task automatic feed(logic [63:0] v);
        col_valid = 1'b1; col_data = v;
        @(posedge clk); #1;
        col_valid = 1'b0;
    endtask

    // One line: fine offset s, upper scroll bits hi (R2), group gg delayed by d ticks (R8)
    task automatic run_line(int line, bit w, int s, int hi, int gg, int d);
        int width = w ? 320 : 256;
        int last  = 16 + width + 2;
        int ng    = 1;
        wide = w; scroll = 10'((hi << 4) | s);
        line_start = 1'b1;
        @(posedge clk); #1;
        line_start = 1'b0;
        scroll = ~scroll;                 // R2: value outside line_start ignored
        check("R1/R6 line start clears", {pix_act, pix_out}, 0);
        feed(grp(line, 0));
        for (int p = 0; p <= last; p++) begin
            int j, idx, ep, ea, ex;
            logic [PW-1:0] sp; logic sa; logic [8:0] sx;
            do_tick();
            ea = (p >= 16 && p < 16 + width) ? 1 : 0;
            ep = 0; ex = 0;
            if (ea == 1) begin
                ex = p - 16;
                j = p - s;                // R3/R4: stream index
                if (j < 16 * gg) idx = j;
                else if (j < 16 * gg + d) idx = -1;
                else idx = j - d;
                ep = (idx < 0) ? 0 : pval(line, idx / 16, idx % 16);
            end
            check("R6 active flag", pix_act, ea);
            check("R4/R5/R8 pixel", pix_out, ep);
            check("R7 index", pix_x, ex);
            if (p % 37 == 5) begin        // R10: idle cycle holds
                sp = pix_out; sa = pix_act; sx = pix_x;
                @(posedge clk); #1;
                check("R10 hold", {sa, sx, sp}, {pix_act, pix_x, pix_out});
            end
            if (load_tick(s, ng - 1, gg, d) < 16 + width) begin
                int ft = (ng == gg && d > 0) ? load_tick(s, ng, gg, d) - 1
                                             : load_tick(s, ng - 1, gg, d);
                if (p == ft) begin        // R9: held group queued behind current
                    feed(grp(line, ng));
                    ng++;
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset pix", pix_out, 0);
        check("R1 reset act", pix_act, 0);
        check("R1 reset x", pix_x, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        do_tick();
        check("R1 no line yet", {pix_act, pix_x, pix_out}, 0);
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 16; s++)
                run_line(m * 16 + s, 1'(m), s, (s * 13 + m * 7) % 64, NOGAP, 0);
        run_line(40, 1'b0, 3, 5, 3, 5);   // R8 underflow gap
        run_line(41, 1'b1, 0, 9, 1, 20);  // R8 long gap, R5
        run_line(42, 1'b1, 9, 33, 19, 2); // R8 late gap
        run_line(43, 1'b0, 15, 63, NOGAP, 0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule